// File: doc/BRIEF.md
# Repeated Masked Search Sequencer

This block walks a table in memory and looks for the first word that meets a condition against one or two key values. A search starts with a one-cycle `start` pulse. On that pulse the block takes a repeat count, an index word, a base address, the condition code, the mask enable, the two keys and a mask word. The index word holds an 18-bit step in its upper half and an 18-bit offset in its lower half.

Each probe reads one word at `base + offset`. It decrements the repeat count, moves the offset on by the step and tests the word. The search ends at the first word that meets the condition, or when the count runs out. A one-cycle `done` pulse then reports the result, and `skip` tells the sequencing logic whether the next instruction is passed over. The count and index that remain are left on `count_out` and `index_out`, so software can locate the matching word.

With masking on, the operand and both keys are reduced to the bits set in the mask word before the test. The memory port is a plain request/valid read. The address and request are held until `mem_valid` is seen, and only one read is ever outstanding.

Top module: `rep_search`

## Requirements
- R1: A start with count_in = 0 issues no read, raises done on the next cycle with skip = 0, count_out = 0 and index_out equal to index_in.
- R2: Every read request carries mem_addr = base_addr + index[17:0] (mod 2^18), using the offset before its update, and request and address are held unchanged until mem_valid.
- R3: Each accepted read (mem_req and mem_valid high together) lowers count_out by one, sets index[17:0] to index[17:0] + index[35:18] (mod 2^18) and leaves index[35:18] unchanged.
- R4: When the word just read meets the condition, done pulses on the cycle after that read is accepted, skip = 1, and no further read is made.
- R5: When the count reaches zero with no word meeting the condition, done pulses with skip = 0 and count_out = 0.
- R6: cond_sel codes: 0 equal to key_a, 1 not equal to key_a, 2 operand <= key_a, 3 operand > key_a, 4 key_a < operand <= key_b, 5 not (key_a < operand <= key_b); codes 6 and 7 are never met.
- R7: With mask_en = 0, codes 2 to 5 compare 36-bit ones'-complement signed values, where all-ones (minus zero) equals zero; codes 0 and 1 compare bit patterns.
- R8: With mask_en = 1, the operand and both keys are ANDed with mask_word, and every code compares the results as unsigned numbers.
- R9: A start pulse while busy is high is ignored; the running search keeps the values latched at its own start.
- R10: After reset, busy, done, skip and mem_req are 0, and count_out and index_out are 0.
- R11: done is high for exactly one cycle per search; busy is high from the cycle after an accepted non-zero start until done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search (taken only while idle) |
| cond_sel | input | 3 | Condition code |
| mask_en | input | 1 | Masked, unsigned comparison |
| key_a | input | 36 | Key, or lower bound for the range codes |
| key_b | input | 36 | Upper bound for the range codes |
| mask_word | input | 36 | Bit mask used when mask_en is set |
| count_in | input | 18 | Repeat count |
| index_in | input | 36 | Step [35:18] and offset [17:0] |
| base_addr | input | 18 | Table base address |
| mem_req | output | 1 | Read request |
| mem_addr | output | 18 | Read address |
| mem_rdata | input | 36 | Read data, valid with mem_valid |
| mem_valid | input | 1 | Read data valid |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search pulse |
| skip | output | 1 | Word found; skip next instruction |
| count_out | output | 18 | Remaining repeat count |
| index_out | output | 36 | Updated index word |

## Verification
A wrong offset or step shows up at once as a wrong `mem_addr` on the next request. It also shows as a wrong `index_out` when `done` fires. A count that is off by one changes how many reads are made, and `done` comes a probe early or late. A condition decoded wrongly, or a sign handled wrongly in the comparator, leaves the read trace intact up to the hit. It shows only in `skip` and in the count and index left at the end, so every code is swept with each mask setting against several tables.

// File: rtl/rsrch_pkg.sv
package rsrch_pkg;

    typedef enum logic [2:0] {
        COND_EQ    = 3'd0,
        COND_NE    = 3'd1,
        COND_LE    = 3'd2,
        COND_GT    = 3'd3,
        COND_IN    = 3'd4,
        COND_OUT   = 3'd5,
        COND_NONE6 = 3'd6,
        COND_NONE7 = 3'd7
    } cond_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_PROBE = 1'b1
    } state_e;

endpackage

// File: rtl/rsrch_cmp.sv
module rsrch_cmp
    import rsrch_pkg::*;
#(
    parameter int WORD_W = 36
) (
    input  logic [2:0]        cond,
    input  logic              masked,
    input  logic [WORD_W-1:0] operand,
    input  logic [WORD_W-1:0] lo,
    input  logic [WORD_W-1:0] hi,
    input  logic [WORD_W-1:0] mask,
    output logic              hit
);

    localparam int VAL_W = WORD_W + 1;

    logic [WORD_W-1:0]       op_m, lo_m, hi_m;
    logic signed [VAL_W-1:0] v_op, v_lo, v_hi;
    logic                    same, op_le_lo, op_le_hi, lo_lt_op, in_rng;

    // Ones'-complement words become signed values; unsigned mode zero-extends.
    function automatic logic signed [VAL_W-1:0] as_val(
        input logic [WORD_W-1:0] x,
        input logic              unsgn
    );
        if (unsgn || !x[WORD_W-1])
            return $signed({1'b0, x});
        else
            return -$signed({1'b0, ~x});
    endfunction

    always_comb begin
        op_m = masked ? (operand & mask) : operand;
        lo_m = masked ? (lo & mask)      : lo;
        hi_m = masked ? (hi & mask)      : hi;

        v_op = as_val(op_m, masked);
        v_lo = as_val(lo_m, masked);
        v_hi = as_val(hi_m, masked);

        same     = (op_m == lo_m);
        op_le_lo = (v_op <= v_lo);
        op_le_hi = (v_op <= v_hi);
        lo_lt_op = (v_lo < v_op);
        in_rng   = lo_lt_op && op_le_hi;

        unique case (cond_e'(cond))
            COND_EQ:  hit = same;
            COND_NE:  hit = !same;
            COND_LE:  hit = op_le_lo;
            COND_GT:  hit = !op_le_lo;
            COND_IN:  hit = in_rng;
            COND_OUT: hit = !in_rng;
            default:  hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/rsrch_idx.sv
module rsrch_idx #(
    parameter int HALF_W = 18
) (
    input  logic [HALF_W-1:0]   base,
    input  logic [2*HALF_W-1:0] index,
    output logic [HALF_W-1:0]   addr,
    output logic [2*HALF_W-1:0] index_next
);

    logic [HALF_W-1:0] step, offs;

    always_comb begin
        step       = index[2*HALF_W-1:HALF_W];
        offs       = index[HALF_W-1:0];
        addr       = base + offs;
        index_next = {step, offs + step};
    end

endmodule

// File: rtl/rep_search.sv
module rep_search
    import rsrch_pkg::*;
#(
    parameter int WORD_W = 36,
    parameter int CNT_W  = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        cond_sel,
    input  logic              mask_en,
    input  logic [WORD_W-1:0] key_a,
    input  logic [WORD_W-1:0] key_b,
    input  logic [WORD_W-1:0] mask_word,
    input  logic [CNT_W-1:0]  count_in,
    input  logic [WORD_W-1:0] index_in,
    input  logic [WORD_W/2-1:0] base_addr,
    output logic              mem_req,
    output logic [WORD_W/2-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_valid,
    output logic              busy,
    output logic              done,
    output logic              skip,
    output logic [CNT_W-1:0]  count_out,
    output logic [WORD_W-1:0] index_out
);

    localparam int HALF_W = WORD_W / 2;

    typedef struct packed {
        state_e              st;
        logic [CNT_W-1:0]    cnt;
        logic [WORD_W-1:0]   idx;
        logic [2:0]          cond;
        logic                masked;
        logic [WORD_W-1:0]   ka;
        logic [WORD_W-1:0]   kb;
        logic [WORD_W-1:0]   msk;
        logic [HALF_W-1:0]   base;
        logic                done;
        logic                skip;
    } regs_t;

    regs_t r_q, r_d;

    logic [HALF_W-1:0] probe_addr;
    logic [WORD_W-1:0] idx_adv;
    logic              probe_hit;
    logic              accept;

    rsrch_idx #(.HALF_W(HALF_W)) u_idx (
        .base       (r_q.base),
        .index      (r_q.idx),
        .addr       (probe_addr),
        .index_next (idx_adv)
    );

    rsrch_cmp #(.WORD_W(WORD_W)) u_cmp (
        .cond    (r_q.cond),
        .masked  (r_q.masked),
        .operand (mem_rdata),
        .lo      (r_q.ka),
        .hi      (r_q.kb),
        .mask    (r_q.msk),
        .hit     (probe_hit)
    );

    assign accept = (r_q.st == ST_PROBE) && mem_valid;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.cnt    = count_in;
                    r_d.idx    = index_in;
                    r_d.cond   = cond_sel;
                    r_d.masked = mask_en;
                    r_d.ka     = key_a;
                    r_d.kb     = key_b;
                    r_d.msk    = mask_word;
                    r_d.base   = base_addr;
                    r_d.skip   = 1'b0;
                    if (count_in == '0)
                        r_d.done = 1'b1;
                    else
                        r_d.st = ST_PROBE;
                end
            end
            ST_PROBE: begin
                if (accept) begin
                    r_d.cnt = r_q.cnt - 1'b1;
                    r_d.idx = idx_adv;
                    if (probe_hit) begin
                        r_d.done = 1'b1;
                        r_d.skip = 1'b1;
                        r_d.st   = ST_IDLE;
                    end else if (r_q.cnt == CNT_W'(1)) begin
                        r_d.done = 1'b1;
                        r_d.st   = ST_IDLE;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st     <= ST_IDLE;
            r_q.cnt    <= '0;
            r_q.idx    <= '0;
            r_q.cond   <= '0;
            r_q.masked <= 1'b0;
            r_q.ka     <= '0;
            r_q.kb     <= '0;
            r_q.msk    <= '0;
            r_q.base   <= '0;
            r_q.done   <= 1'b0;
            r_q.skip   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_req   = (r_q.st == ST_PROBE);
    assign mem_addr  = probe_addr;
    assign busy      = (r_q.st == ST_PROBE);
    assign done      = r_q.done;
    assign skip      = r_q.skip;
    assign count_out = r_q.cnt;
    assign index_out = r_q.idx;

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_valid) |=> (count_out == $past(count_out) - 1'b1));

    // R3
    step_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_valid) |=>
            (index_out[WORD_W-1:HALF_W] == $past(index_out[WORD_W-1:HALF_W])));

    // R1
    zero_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && count_in == '0) |=> (done && !skip && !mem_req));

    // R5
    exhaust_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !skip) |-> (count_out == '0));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !mem_valid) |=> busy);

    // R6
    undef_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && r_q.cond[2:1] == 2'b11) |-> !skip);

endmodule

// File: tb/rep_search_test.sv
module rep_search_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  cond_sel = '0;
    logic        mask_en = 1'b0;
    logic [35:0] key_a = '0, key_b = '0, mask_word = '0;
    logic [17:0] count_in = '0;
    logic [35:0] index_in = '0;
    logic [17:0] base_addr = '0;
    logic        mem_req;
    logic [17:0] mem_addr;
    logic [35:0] mem_rdata;
    logic        mem_valid;
    logic        busy, done, skip;
    logic [17:0] count_out;
    logic [35:0] index_out;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rep_search uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cond_sel(cond_sel),
        .mask_en(mask_en), .key_a(key_a), .key_b(key_b), .mask_word(mask_word),
        .count_in(count_in), .index_in(index_in), .base_addr(base_addr),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_valid(mem_valid), .busy(busy), .done(done), .skip(skip),
        .count_out(count_out), .index_out(index_out)
    );

    // memory model: one read at a time, configurable wait
    logic [35:0] memw [32];
    int          lat = 0;
    logic        pend = 1'b0, vld = 1'b0;
    int          wcnt = 0;
    logic [17:0] lat_addr = '0;
    logic [35:0] rd = '0;
    int          probes = 0;
    logic [17:0] addr_log [256];

    assign mem_valid = vld;
    assign mem_rdata = rd;

    always @(posedge clk) begin
        if (vld) begin
            vld  <= 1'b0;
            pend <= 1'b0;
        end else if (mem_req && !pend) begin
            pend     <= 1'b1;
            wcnt     <= lat;
            lat_addr <= mem_addr;
        end else if (pend) begin
            if (wcnt == 0) begin
                vld <= 1'b1;
                rd  <= memw[lat_addr[4:0]];
            end else begin
                wcnt <= wcnt - 1;
            end
        end
        if (mem_req && mem_valid) begin
            addr_log[probes[7:0]] <= mem_addr;
            probes <= probes + 1;
        end
    end

    task automatic finish_up;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R11 watchdog expired: actual hung expected done");
        finish_up();
    end

    function automatic longint oc_val(logic [35:0] x);
        logic [35:0] nx;
        nx = ~x;
        if (x[35]) return -longint'({28'd0, nx});
        return longint'({28'd0, x});
    endfunction

    function automatic bit ref_hit(int c, bit msk, logic [35:0] op,
                                   logic [35:0] a, logic [35:0] b, logic [35:0] m);
        longint vo, va, vb;
        bit     eq, inr;
        if (msk) begin
            vo = longint'({28'd0, op & m});
            va = longint'({28'd0, a & m});
            vb = longint'({28'd0, b & m});
            eq = ((op & m) == (a & m));
        end else begin
            vo = oc_val(op);
            va = oc_val(a);
            vb = oc_val(b);
            eq = (op == a);
        end
        inr = (va < vo) && (vo <= vb);
        case (c)
            0: return eq;
            1: return !eq;
            2: return vo <= va;
            3: return vo > va;
            4: return inr;
            5: return !inr;
            default: return 1'b0;
        endcase
    endfunction

    task automatic run(int c, bit msk, int k, logic [35:0] idx, logic [17:0] base,
                       logic [35:0] a, logic [35:0] b, logic [35:0] m, bit poke);
        logic [17:0] mod, inc, ad;
        logic [17:0] exp_addr [8];
        int          left, np, p0, w;
        bit          hit;
        string       lbl;
        mod  = idx[17:0];
        inc  = idx[35:18];
        left = k;
        hit  = 1'b0;
        np   = 0;
        while (left > 0 && !hit) begin
            ad = base + mod;
            exp_addr[np] = ad;
            np++;
            left--;
            hit = ref_hit(c, msk, memw[ad[4:0]], a, b, m);
            mod = mod + inc;
        end
        lbl = msk ? "R8" : ((c >= 2 && c <= 5) ? "R7" : "R6");

        @(negedge clk);
        p0 = probes;
        cond_sel = 3'(c); mask_en = msk; key_a = a; key_b = b; mask_word = m;
        count_in = 18'(k); index_in = idx; base_addr = base;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (k != 0) chk("R11", "busy after start", 64'(busy), 64'd1);
        if (poke) begin
            start = 1'b1;
            count_in = '0;
            index_in = 36'h5_5555_5555;
            base_addr = 18'h1F;
            @(negedge clk);
            start = 1'b0;
        end
        w = 0;
        while (!done && w < 400) begin
            @(negedge clk);
            w++;
        end
        if (k == 0) begin
            chk("R1", "done latency", 64'(w), 64'd0);
            chk("R1", "index kept", 64'(index_out), 64'(idx));
        end
        chk(lbl, $sformatf("skip cond=%0d msk=%0d", c, msk), 64'(skip), 64'(hit));
        chk(hit ? "R4" : "R5", "remaining count", 64'(count_out), 64'(left));
        chk(poke ? "R9" : "R3", "index out", 64'(index_out), 64'({inc, mod}));
        chk("R4", "probe count", 64'(probes - p0), 64'(np));
        chk("R11", "busy at done", 64'(busy), 64'd0);
        for (int i = 0; i < np; i++)
            chk("R2", "probe address", 64'(addr_log[8'(p0 + i)]), 64'(exp_addr[i]));
        @(negedge clk);
        chk("R11", "done one cycle", 64'(done), 64'd0);
    endtask

    initial begin
        logic [35:0] t, a, b, m, idx;
        logic [17:0] base, inc, mod, ka_ad;
        repeat (3) @(negedge clk);
        chk("R10", "busy", 64'(busy), 64'd0);
        chk("R10", "done", 64'(done), 64'd0);
        chk("R10", "skip", 64'(skip), 64'd0);
        chk("R10", "mem_req", 64'(mem_req), 64'd0);
        chk("R10", "count_out", 64'(count_out), 64'd0);
        chk("R10", "index_out", 64'(index_out), 64'd0);
        rst_n = 1'b1;

        for (int p = 0; p < 3; p++) begin
            for (int i = 0; i < 32; i++) begin
                t = 36'(i) * 36'h1F3A5C7 + 36'(p) * 36'h9E3779B9;
                memw[i] = t ^ {t[5:0], 30'b0};
            end
            inc  = (p == 0) ? 18'd1 : (p == 1) ? 18'd3 : 18'h3FFFF;
            m    = (p == 0) ? 36'hFFF000FFF : (p == 1) ? 36'h0000FFFFF : 36'h8F0F0F0F0;
            base = 18'(7 * p);
            for (int c = 0; c < 8; c++) begin
                for (int s = 0; s < 2; s++) begin
                    foreach (memw[q]) begin end
                    for (int kk = 0; kk < 4; kk++) begin
                        int k;
                        k   = (kk == 0) ? 0 : (kk == 1) ? 1 : (kk == 2) ? 3 : 7;
                        mod = (p == 1) ? 18'h3FFFE : 18'(p * 5 + c);
                        idx = {inc, mod};
                        ka_ad = base + mod + inc + inc;
                        a = (p == 1) ? 36'h0_8000_0000 : memw[ka_ad[4:0]];
                        b = a + 36'h0_1000_0000;
                        lat = (p + c + kk) % 3;
                        run(c, s[0], k, idx, base, a, b, m, (k == 7 && s == 1));
                    end
                end
            end
        end

        // minus zero against zero
        memw[0] = 36'hF_FFFF_FFFF;
        lat = 0;
        run(2, 1'b0, 1, 36'd0, 18'd0, 36'd0, 36'd5, 36'd0, 1'b0);
        chk("R7", "minus zero <= zero", 64'(skip), 64'd1);
        run(3, 1'b0, 1, 36'd0, 18'd0, 36'd0, 36'd5, 36'd0, 1'b0);
        chk("R7", "minus zero > zero", 64'(skip), 64'd0);
        run(0, 1'b0, 1, 36'd0, 18'd0, 36'd0, 36'd5, 36'd0, 1'b0);
        chk("R7", "equal is bitwise", 64'(skip), 64'd0);

        finish_up();
    end

endmodule